// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This block is a memory-mapped real-time clock core. A tick-enable input arrives from a slow crystal reference of nominally 33.330 kHz and is already synchronised to the system clock. The block counts these ticks into one-second events. The number of ticks per second is programmable. An optional fractional trim adds one tick to some seconds so that the average period follows a crystal that runs off its nominal rate.

The block keeps a 32-bit seconds count. Software sets the time in two steps. It writes a new value to the set-time register, and that value is moved into the seconds count only at the next seconds event. Until then, software can read back the pending value. A write to the calibration register restarts the tick counter, so the next seconds event comes exactly one full period after that write. Each seconds event sets a sticky status flag, which software clears by writing 1 to it. The interrupt output follows this flag when the interrupt enable is set.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset, the calibration register reads 0x198233. The seconds count, set-time value, status flag and control register read 0, and `sec_irq` is low.
- R2: Registers are decoded on `reg_addr`: 0x00 set-time write, 0x04 set-time readback, 0x08 calibration, 0x10 current seconds, 0x20 status, 0x40 control. Any other address reads 0. `reg_rdata` is combinational from `reg_addr`.
- R3: The calibration register stores only bits [20:0] of the written word. Bits [31:21] read as 0.
- R4: Calibration bits [15:0] give N, the number of ticks in one second. Any calibration write clears the tick counter. The next seconds event then comes on the N-th clock edge with `tick_en` high after the write.
- R5: When calibration bit 20 is 1, a 4-bit accumulator adds the step in bits [19:16] at every seconds event. A second whose addition carries out of 4 bits lasts N+1 ticks. When bit 20 is 0, the accumulator holds.
- R6: A write to 0x00 does not change the current seconds count at once. The value is copied into the count at the next seconds event. Reads at 0x04 return the value most recently written to 0x00.
- R7: At a seconds event with no set-time value pending, the count increments by one modulo 2^32. Between events it holds.
- R8: Status bit 0 becomes 1 at every seconds event. Writing 1 to bit 0 at 0x20 clears it, and writing 0 leaves it unchanged. If a seconds event and a clear fall in the same cycle, the flag ends up set.
- R9: Control bit 31 (battery enable) and bit 0 (interrupt enable) are readable and writable. The other control bits read 0. Both stored bits keep their value across accesses to other registers.
- R10: `sec_irq` is high exactly when status bit 0 and control bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per reference tick, already synchronised |
| reg_addr | input | 7 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sec_irq | output | 1 | Seconds interrupt |

## Verification
The bench measures the length of each second in ticks. A design that ignores the calibration restart would give a short second after a mid-second calibration write. A design that applies the fractional carry in the wrong second would give the 4/5/4 pattern out of phase. The bench reads the current count right after a set-time write, and a design that loads the value at once is caught there. It also runs the count across 0xFFFFFFFF to check the wrap. The remaining checks cover three things: that a write of 0 leaves the sticky flag set, that the control bits keep their value when other registers are written, and that the interrupt depends on the enable bit as well as the flag.

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core #(
  parameter int AW = 7,
  parameter int DW = 32,
  parameter int CNT_W = 16,
  parameter int FRAC_W = 4,
  parameter logic [CNT_W+FRAC_W:0] CAL_RST = 21'h198233
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sec_irq
);
  localparam int CAL_W = CNT_W + FRAC_W + 1;
  localparam logic [AW-1:0] A_SETW = AW'('h00);
  localparam logic [AW-1:0] A_SETR = AW'('h04);
  localparam logic [AW-1:0] A_CAL  = AW'('h08);
  localparam logic [AW-1:0] A_CUR  = AW'('h10);
  localparam logic [AW-1:0] A_STS  = AW'('h20);
  localparam logic [AW-1:0] A_CTL  = AW'('h40);

  logic [CAL_W-1:0]  cal;
  logic [CNT_W-1:0]  tick_cnt;
  logic [FRAC_W-1:0] frac_acc;
  logic [DW-1:0]     set_val, cur;
  logic              pending, sts, irq_en, batt_en;

  wire cal_wr = reg_wr && reg_addr == A_CAL;
  wire set_wr = reg_wr && reg_addr == A_SETW;
  wire sts_wr = reg_wr && reg_addr == A_STS;
  wire ctl_wr = reg_wr && reg_addr == A_CTL;

  wire [CNT_W-1:0]  cal_div  = cal[CNT_W-1:0];
  wire [FRAC_W-1:0] cal_frac = cal[CNT_W+FRAC_W-1:CNT_W];
  wire              cal_fen  = cal[CAL_W-1];
  wire [FRAC_W:0]   acc_sum  = {1'b0, frac_acc} + {1'b0, cal_frac};
  wire              extra    = cal_fen & acc_sum[FRAC_W];
  wire [CNT_W:0]    last     = {1'b0, cal_div} + (CNT_W+1)'(extra) - (CNT_W+1)'(1);
  wire              sec_evt  = tick_en && ({1'b0, tick_cnt} == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal      <= CAL_RST;
      tick_cnt <= '0;
      frac_acc <= '0;
    end else begin
      if (cal_wr) cal <= reg_wdata[CAL_W-1:0];
      if (cal_wr) tick_cnt <= '0;
      else if (sec_evt) tick_cnt <= '0;
      else if (tick_en) tick_cnt <= tick_cnt + 1'b1;
      if (sec_evt && cal_fen) frac_acc <= acc_sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_val <= '0;
      cur     <= '0;
      pending <= 1'b0;
    end else begin
      if (sec_evt) cur <= pending ? set_val : cur + 1'b1;
      if (set_wr) begin
        set_val <= reg_wdata;
        pending <= 1'b1;
      end else if (sec_evt) begin
        pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts     <= 1'b0;
      irq_en  <= 1'b0;
      batt_en <= 1'b0;
    end else begin
      if (sec_evt) sts <= 1'b1;
      else if (sts_wr && reg_wdata[0]) sts <= 1'b0;
      if (ctl_wr) begin
        irq_en  <= reg_wdata[0];
        batt_en <= reg_wdata[DW-1];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_SETR:  reg_rdata = set_val;
      A_CAL:   reg_rdata = DW'(cal);
      A_CUR:   reg_rdata = cur;
      A_STS:   reg_rdata = DW'(sts);
      A_CTL:   reg_rdata = {batt_en, {(DW-2){1'b0}}, irq_en};
      default: reg_rdata = '0;
    endcase
  end

  assign sec_irq = sts & irq_en;
endmodule

module rtc_seconds_core_chk #(
  parameter int DW = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_evt,
  input logic             pending,
  input logic             set_wr,
  input logic             cal_wr,
  input logic [DW-1:0]    set_val,
  input logic [DW-1:0]    cur,
  input logic             sts,
  input logic [CNT_W-1:0] tick_cnt
);
  p_cal_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr |=> tick_cnt == '0);
  p_load_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && pending) |=> cur == $past(set_val));
  p_wait_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> pending);
  p_increment_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !pending) |=> cur == $past(cur) + 1'b1);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_evt |=> $stable(cur));
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> sts);
endmodule

bind rtc_seconds_core rtc_seconds_core_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .pending(pending),
  .set_wr(set_wr), .cal_wr(cal_wr), .set_val(set_val), .cur(cur),
  .sts(sts), .tick_cnt(tick_cnt)
);

// File: tb/rtc_seconds_core_tb.sv
module rtc_seconds_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sec_irq;
  int total = 0;
  int bad = 0;
  logic [31:0] v;
  int n;

  always #10 clk = ~clk;

  rtc_seconds_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_irq(sec_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_sec(output int ticks);
    logic [31:0] s;
    ticks = 0;
    @(negedge clk);
    tick_en = 1'b1;
    do begin
      @(negedge clk);
      ticks++;
      rd(7'h20, s);
    end while (s[0] == 1'b0 && ticks < 1000);
    tick_en = 1'b0;
    wr(7'h20, 32'h1);
  endtask

  task automatic t_reset;
    rd(7'h08, v); check("R1 cal reset", v, 32'h198233);
    rd(7'h10, v); check("R1 cur reset", v, 0);
    rd(7'h04, v); check("R1 setval reset", v, 0);
    rd(7'h20, v); check("R1 sts reset", v, 0);
    rd(7'h40, v); check("R1 ctl reset", v, 0);
    check("R1 irq reset", {31'b0, sec_irq}, 0);
    rd(7'h0C, v); check("R2 unmapped", v, 0);
  endtask

  task automatic t_cal_mask;
    wr(7'h08, 32'hFFFF_FFFF);
    rd(7'h08, v); check("R3 cal mask", v, 32'h001F_FFFF);
    wr(7'h08, 32'd5);
    rd(7'h08, v); check("R2 cal readback", v, 32'd5);
  endtask

  task automatic t_period;
    run_sec(n); check("R4 period", n, 5);
    @(negedge clk); tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    wr(7'h08, 32'd5);
    run_sec(n); check("R4 restart", n, 5);
  endtask

  task automatic t_frac;
    wr(7'h08, (32'h1 << 20) | (32'h8 << 16) | 32'd4);
    run_sec(n); check("R5 sec1", n, 4);
    run_sec(n); check("R5 sec2 carry", n, 5);
    run_sec(n); check("R5 sec3", n, 4);
    wr(7'h08, 32'd5);
  endtask

  task automatic t_settime;
    logic [31:0] c0;
    rd(7'h10, c0);
    wr(7'h00, 32'd100);
    rd(7'h04, v); check("R6 readback", v, 100);
    rd(7'h10, v); check("R6 not immediate", v, c0);
    run_sec(n);
    rd(7'h10, v); check("R6 loaded", v, 100);
    rd(7'h04, v); check("R6 readback kept", v, 100);
    run_sec(n);
    rd(7'h10, v); check("R7 increment", v, 101);
    wr(7'h00, 32'hFFFF_FFFF);
    run_sec(n);
    rd(7'h10, v); check("R6 load max", v, 32'hFFFF_FFFF);
    run_sec(n);
    rd(7'h10, v); check("R7 wrap", v, 0);
  endtask

  task automatic t_status;
    rd(7'h20, v); check("R8 cleared", v, 0);
    @(negedge clk); tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    rd(7'h20, v); check("R8 set", v, 1);
    wr(7'h20, 32'h0);
    rd(7'h20, v); check("R8 write0 keeps", v, 1);
    wr(7'h20, 32'h1);
    rd(7'h20, v); check("R8 w1c", v, 0);
  endtask

  task automatic t_ctrl;
    @(negedge clk); tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    #1 check("R10 irq masked", {31'b0, sec_irq}, 0);
    wr(7'h40, 32'hFFFF_FFFF);
    rd(7'h40, v); check("R9 ctl bits", v, 32'h8000_0001);
    check("R10 irq on", {31'b0, sec_irq}, 1);
    wr(7'h00, 32'd7);
    wr(7'h08, 32'd5);
    rd(7'h40, v); check("R9 ctl held", v, 32'h8000_0001);
    wr(7'h20, 32'h1);
    #1 check("R10 irq after clear", {31'b0, sec_irq}, 0);
    wr(7'h40, 32'h8000_0000);
    rd(7'h40, v); check("R9 batt only", v, 32'h8000_0000);
    @(negedge clk); tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    rd(7'h20, v); check("R8 set again", v, 1);
    check("R10 irq disabled", {31'b0, sec_irq}, 0);
  endtask

  initial begin
    #100000000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cal_mask();
    t_period();
    t_frac();
    t_settime();
    t_status();
    t_ctrl();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule